// File: doc/BRIEF.md
# Age-Ordered Issue Queue with Replay Slot Bypass

This block is the integer-side issue queue of an out-of-order core. It takes at most one instruction per cycle in program order and issues at most one per cycle. The oldest entry that is ready always wins. The queue holds integer operations, loads, stores and moves from integer to floating-point registers. Some of these entries read a floating-point source register. A 32-bit scoreboard tracks which floating-point registers still wait for a result. An entry that reads such a source stays in the queue until that register is clean.

A memory replay trap refetches a load or store. If the refetched store reads a floating-point source, a fresh dirty check could hold it back. Newer memory operations would then issue ahead of it and could trigger the trap again. To prevent this, the block records the trap's position inside the fetch block (the low two bits of the PC) in a one-shot marker. The next accepted enqueue at that position clears the marker. If that instruction reads a floating-point source, it enters as clean and needs no scoreboard check.

A flush empties the queue and drops the marker. The scoreboard keeps its contents through a flush.

Top module: `replay_bypass_iq`

## Requirements
- R1: After reset the queue is empty, `iss_valid` is 0, `enq_ready` is 1, no marker is pending and every scoreboard bit is clean.
- R2: An enqueue is accepted when `enq_valid` and `enq_ready` are both 1. `enq_ready` is 0 while the queue holds DEPTH (8) entries, and an enqueue offered in that state is dropped.
- R3: Each cycle, at most one entry issues: the oldest ready entry in program order. A younger ready entry may pass an older one that is blocked. An entry can issue from the cycle after the cycle it is accepted in.
- R4: An entry with `enq_fp_src` = 0 is ready from the cycle after its acceptance, with no added delay.
- R5: An entry with `enq_fp_src` = 1 that is not bypassed is ready only in a cycle where its source register is clean. A writeback to that register in the same cycle counts as clean.
- R6: An accepted enqueue with `enq_dst_valid` = 1 marks `enq_dst` dirty, and `wb_valid` marks `wb_idx` clean. When both name the same register in one cycle, the register becomes dirty.
- R7: `replay_valid` stores `replay_slot` in the marker. A later replay overwrites a marker that is still pending.
- R8: The next accepted enqueue whose `enq_slot` equals the pending marker's slot clears the marker, whatever kind of instruction it is. If that entry reads a floating-point source, it is ready without any scoreboard check.
- R9: `flush` empties the queue and clears the marker. In the flush cycle, no entry issues and any enqueue or replay is dropped. The scoreboard keeps its state.
- R10: When an enqueue and a replay fall in the same cycle, the enqueue is matched against the marker that was pending before that cycle. The newly stored replay slot stays pending after the enqueue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and clear the marker |
| enq_valid | input | 1 | Offer an instruction for enqueue |
| enq_slot | input | 2 | Position of the instruction in its fetch block |
| enq_fp_src | input | 1 | Instruction reads a floating-point source |
| enq_src | input | 5 | Floating-point source register index |
| enq_dst_valid | input | 1 | Instruction allocates a floating-point destination |
| enq_dst | input | 5 | Floating-point destination register index |
| enq_tag | input | 4 | Identifier carried to the issue port |
| enq_ready | output | 1 | Queue can accept an instruction this cycle |
| replay_valid | input | 1 | Memory replay trap signalled |
| replay_slot | input | 2 | Fetch-block position of the replayed instruction |
| wb_valid | input | 1 | Floating-point register writeback |
| wb_idx | input | 5 | Register index being written back |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_tag | output | 4 | Identifier of the issuing entry |

## Verification
Three pairs of events can fall in the same cycle:
- **Enqueue that consumes the marker, plus a new replay trap.** The bench drives both in one cycle. Then, in the next cycle, it enqueues a floating-point store with a dirty source at the replayed slot. The store must issue one cycle later, which shows that the new marker survived.
- **Destination allocation and writeback to the same register.** The bench drives both together. A dependent store must then wait until a later writeback.
- **Writeback and readiness check.** When a writeback arrives in the cycle a waiting store is checked, the store must issue in that same cycle.

// File: rtl/sbiq_pkg.sv
package sbiq_pkg;

    // position of an instruction inside a four-wide fetch block
    localparam int SLOT_W = 2;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
    } mark_t;

endpackage

// File: rtl/sbiq_fpr_board.sv
module sbiq_fpr_board #(
    parameter int NUM_FPR = 32,
    localparam int IDX_W  = $clog2(NUM_FPR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               wb_valid,
    input  logic [IDX_W-1:0]   wb_idx,
    output logic [NUM_FPR-1:0] clean_vec
);

    typedef struct packed {
        logic [NUM_FPR-1:0] dirty;
    } board_t;

    board_t st_d, st_q;
    logic [NUM_FPR-1:0] wb_hot;

    always_comb begin
        wb_hot = '0;
        if (wb_valid) wb_hot[wb_idx] = 1'b1;
        // a writeback landing this cycle already counts as clean
        clean_vec = ~st_q.dirty | wb_hot;

        st_d = st_q;
        st_d.dirty = st_d.dirty & ~wb_hot;
        // allocation applied last: a new producer wins over an old result
        if (alloc_valid) st_d.dirty[alloc_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> st_q.dirty[$past(alloc_idx)]);

    p_wb_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(alloc_valid && alloc_idx == wb_idx)) |=> !st_q.dirty[$past(wb_idx)]);

endmodule

// File: rtl/sbiq_slot_marker.sv
module sbiq_slot_marker
    import sbiq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              replay_valid,
    input  logic [SLOT_W-1:0] replay_slot,
    input  logic              enq_fire,
    input  logic [SLOT_W-1:0] enq_slot,
    output logic              hit
);

    mark_t st_d, st_q;

    always_comb begin
        // match uses the marker held before this cycle
        hit  = st_q.vld && (enq_slot == st_q.slot);
        st_d = st_q;
        if (enq_fire && hit) st_d.vld = 1'b0;
        if (replay_valid) begin
            st_d.vld  = 1'b1;
            st_d.slot = replay_slot;
        end
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid && !flush) |=> (st_q.vld && st_q.slot == $past(replay_slot)));

    p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire && hit && !replay_valid) |=> !st_q.vld);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !st_q.vld);

endmodule

// File: rtl/sbiq_age_pick.sv
module sbiq_age_pick #(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ready,
    output logic [DEPTH-1:0] grant,
    output logic [PTR_W-1:0] grant_idx,
    output logic             any
);

    // index 0 holds the oldest entry
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && ready[i]) begin
                grant[i]  = 1'b1;
                grant_idx = PTR_W'(i);
                found     = 1'b1;
            end
        end
        any = found;
    end

    p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_is_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~ready) == '0);

    p_none_older_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((ready & (grant - 1'b1)) == '0));

endmodule

// File: rtl/replay_bypass_iq.sv
module replay_bypass_iq
    import sbiq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NUM_FPR = 32,
    parameter int TAG_W   = 4,
    localparam int IDX_W  = $clog2(NUM_FPR),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              enq_valid,
    input  logic [SLOT_W-1:0] enq_slot,
    input  logic              enq_fp_src,
    input  logic [IDX_W-1:0]  enq_src,
    input  logic              enq_dst_valid,
    input  logic [IDX_W-1:0]  enq_dst,
    input  logic [TAG_W-1:0]  enq_tag,
    output logic              enq_ready,
    input  logic              replay_valid,
    input  logic [SLOT_W-1:0] replay_slot,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag
);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0]            chk;   // entry still needs a scoreboard check
        logic [DEPTH-1:0][IDX_W-1:0] src;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } queue_t;

    queue_t st_d, st_q;

    logic               enq_fire;
    logic               mark_hit;
    logic [NUM_FPR-1:0] fpr_clean;
    logic [DEPTH-1:0]   ready;
    logic [DEPTH-1:0]   grant;
    logic [PTR_W-1:0]   pick_idx;
    logic               pick_any;
    logic               iss_fire;
    logic [CNT_W-1:0]   cnt_after;

    assign enq_ready = (st_q.cnt != CNT_W'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready && !flush;

    sbiq_fpr_board #(.NUM_FPR(NUM_FPR)) u_board (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (enq_fire && enq_dst_valid),
        .alloc_idx   (enq_dst),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .clean_vec   (fpr_clean)
    );

    sbiq_slot_marker u_marker (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .replay_valid (replay_valid),
        .replay_slot  (replay_slot),
        .enq_fire     (enq_fire),
        .enq_slot     (enq_slot),
        .hit          (mark_hit)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ready[i] = (CNT_W'(i) < st_q.cnt) &&
                       (!st_q.chk[i] || fpr_clean[st_q.src[i]]);
        end
    end

    sbiq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .grant     (grant),
        .grant_idx (pick_idx),
        .any       (pick_any)
    );

    assign iss_fire  = pick_any && !flush;
    assign iss_valid = iss_fire;
    assign iss_tag   = pick_any ? st_q.tag[pick_idx] : '0;

    always_comb begin
        st_d = st_q;
        // collapse the issued slot so index order stays program order
        if (iss_fire) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (PTR_W'(i) >= pick_idx) begin
                    st_d.chk[i] = st_q.chk[i+1];
                    st_d.src[i] = st_q.src[i+1];
                    st_d.tag[i] = st_q.tag[i+1];
                end
            end
        end
        cnt_after = st_q.cnt - CNT_W'(iss_fire);
        if (enq_fire) begin
            st_d.chk[PTR_W'(cnt_after)] = enq_fp_src && !mark_hit;
            st_d.src[PTR_W'(cnt_after)] = enq_src;
            st_d.tag[PTR_W'(cnt_after)] = enq_tag;
        end
        st_d.cnt = cnt_after + CNT_W'(enq_fire);
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire && !iss_fire) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && !iss_valid));

endmodule

// File: tb/replay_bypass_iq_test.sv
module replay_bypass_iq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush, enq_valid, enq_fp_src, enq_dst_valid, replay_valid, wb_valid;
    logic [1:0] enq_slot, replay_slot;
    logic [4:0] enq_src, enq_dst, wb_idx;
    logic [3:0] enq_tag;
    logic       enq_ready, iss_valid;
    logic [3:0] iss_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    replay_bypass_iq uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_valid(enq_valid), .enq_slot(enq_slot), .enq_fp_src(enq_fp_src),
        .enq_src(enq_src), .enq_dst_valid(enq_dst_valid), .enq_dst(enq_dst),
        .enq_tag(enq_tag), .enq_ready(enq_ready),
        .replay_valid(replay_valid), .replay_slot(replay_slot),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .iss_valid(iss_valid), .iss_tag(iss_tag)
    );

    typedef struct packed {
        logic enq; logic [1:0] slot; logic fps; logic [4:0] src;
        logic dv; logic [4:0] dst; logic [3:0] tag;
        logic rep; logic [1:0] rslot; logic wb; logic [4:0] wbi; logic fl;
        logic xiv; logic [3:0] xtag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{1,0,0, 0,1, 3, 1, 0,0,0,0,0, 0, 0}, // R4 int op allocates f3
        '{0,0,0, 0,0, 0, 0, 1,2,0,0,0, 1, 1}, // R4 issues next cycle, R7 trap slot 2
        '{1,2,1, 3,0, 0, 2, 0,0,0,0,0, 0, 0}, // R8 fp store slot 2, f3 dirty
        '{1,3,0, 0,0, 0, 3, 0,0,0,0,0, 1, 2}, // R8 bypassed store issues first
        '{1,2,1, 3,0, 0, 4, 0,0,0,0,0, 1, 3}, // R3 load follows; marker gone
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 0, 0}, // R5 store 4 waits on f3
        '{0,0,0, 0,0, 0, 0, 0,0,1,3,0, 1, 4}, // R5 same-cycle writeback is clean
        '{1,1,1, 3,0, 0, 5, 0,0,0,0,0, 0, 0},
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 1, 5}, // R5 clean source ready at once
        '{0,0,0, 0,0, 0, 0, 1,1,0,0,0, 0, 0}, // R7 trap slot 1
        '{1,1,0, 0,1, 7, 6, 0,0,0,0,0, 0, 0}, // R8 int op consumes marker
        '{1,1,1, 7,0, 0, 7, 0,0,0,0,0, 1, 6},
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 0, 0}, // R8 store 7 not bypassed
        '{0,0,0, 0,0, 0, 0, 0,0,1,7,0, 1, 7},
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 0, 0},
        '{1,0,0, 0,1, 9, 8, 0,0,0,0,0, 0, 0},
        '{1,0,1, 9,0, 0, 9, 0,0,0,0,0, 1, 8},
        '{1,0,0, 0,0, 0,10, 0,0,0,0,0, 0, 0},
        '{1,0,0, 0,0, 0,11, 0,0,0,0,0, 1,10}, // R3 younger passes blocked older
        '{0,0,0, 0,0, 0, 0, 0,0,1,9,0, 1, 9}, // R3 oldest ready wins
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 1,11},
        '{0,0,0, 0,0, 0, 0, 0,0,0,0,0, 0, 0}
    };

    task automatic drv(input logic e, input logic [1:0] s, input logic f, input logic [4:0] sr,
                       input logic dv, input logic [4:0] d, input logic [3:0] t,
                       input logic r, input logic [1:0] rs, input logic w, input logic [4:0] wi,
                       input logic fl);
        enq_valid = e; enq_slot = s; enq_fp_src = f; enq_src = sr;
        enq_dst_valid = dv; enq_dst = d; enq_tag = t;
        replay_valid = r; replay_slot = rs; wb_valid = w; wb_idx = wi; flush = fl;
    endtask

    task automatic idle();
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs are set at a falling edge; outputs are judged 1 ns later
    task automatic step(input logic xiv, input logic [3:0] xtag, input string req);
        #1;
        chk({req, " iss_valid"}, int'(iss_valid), int'(xiv));
        if (xiv) chk({req, " iss_tag"}, int'(iss_tag), int'(xtag));
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset enq_ready", int'(enq_ready), 1);
        chk("R1 reset iss_valid", int'(iss_valid), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk);
        do_reset();

        for (int k = 0; k < NV; k++) begin
            drv(VT[k].enq, VT[k].slot, VT[k].fps, VT[k].src, VT[k].dv, VT[k].dst, VT[k].tag,
                VT[k].rep, VT[k].rslot, VT[k].wb, VT[k].wbi, VT[k].fl);
            step(VT[k].xiv, VT[k].xtag, $sformatf("vector %0d", k));
        end

        // R2: fill to depth with stores blocked on f12, then offer one more
        do_reset();
        drv(1, 0, 0, 0, 1, 12, 0, 0, 0, 0, 0, 0); step(0, 0, "R2 alloc f12");
        step(1, 0, "R2 producer issues");
        for (int k = 1; k <= 8; k++) begin
            #1; chk("R2 enq_ready below depth", int'(enq_ready), 1);
            drv(1, 0, 1, 12, 0, 0, 4'(k), 0, 0, 0, 0, 0);
            step(0, 0, "R2 fill");
        end
        #1; chk("R2 enq_ready at depth", int'(enq_ready), 0);
        drv(1, 0, 0, 0, 0, 0, 4'd15, 0, 0, 0, 0, 0); step(0, 0, "R2 full offer");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 12, 0); step(1, 1, "R2 drain");
        for (int k = 2; k <= 8; k++) step(1, 4'(k), "R2 drain order");
        step(0, 0, "R2 dropped offer absent");

        // R9: flush drops queue, marker, enqueue and replay; scoreboard stays
        do_reset();
        drv(1, 0, 0, 0, 1, 20, 1, 0, 0, 0, 0, 0); step(0, 0, "R9 alloc f20");
        drv(1, 0, 1, 20, 0, 0, 2, 1, 3, 0, 0, 0); step(1, 1, "R9 before flush");
        drv(1, 0, 0, 0, 0, 0, 9, 1, 3, 0, 0, 1); step(0, 0, "R9 flush cycle no issue");
        drv(1, 3, 1, 20, 0, 0, 3, 0, 0, 0, 0, 0); step(0, 0, "R9 after flush");
        step(0, 0, "R9 marker cleared, f20 still dirty");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 20, 0); step(1, 3, "R9 waits for writeback");
        step(0, 0, "R9 flushed entries gone");

        // R10: consume and new trap in one cycle
        do_reset();
        drv(1, 0, 0, 0, 1, 21, 1, 1, 2, 0, 0, 0); step(0, 0, "R10 setup");
        drv(1, 2, 0, 0, 0, 0, 2, 1, 2, 0, 0, 0); step(1, 1, "R10 consume plus trap");
        drv(1, 2, 1, 21, 0, 0, 3, 0, 0, 0, 0, 0); step(1, 2, "R10 store enqueued");
        step(1, 3, "R10 new marker bypasses store");

        // R7: later trap overwrites pending one
        do_reset();
        drv(1, 0, 0, 0, 1, 22, 1, 1, 1, 0, 0, 0); step(0, 0, "R7 trap slot 1");
        drv(0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0); step(1, 1, "R7 trap slot 3");
        drv(1, 1, 1, 22, 0, 0, 2, 0, 0, 0, 0, 0); step(0, 0, "R7 store slot 1");
        drv(1, 3, 1, 22, 0, 0, 3, 0, 0, 0, 0, 0); step(0, 0, "R7 slot 1 not bypassed");
        step(1, 3, "R7 slot 3 bypassed");
        step(0, 0, "R7 slot 1 store waits");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 22, 0); step(1, 2, "R7 released by writeback");

        // R6: allocation and writeback to one register in one cycle
        do_reset();
        drv(1, 0, 0, 0, 1, 25, 1, 0, 0, 1, 25, 0); step(0, 0, "R6 alloc with writeback");
        drv(1, 0, 1, 25, 0, 0, 2, 0, 0, 0, 0, 0); step(1, 1, "R6 producer");
        step(0, 0, "R6 allocation wins, store waits");
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 25, 0); step(1, 2, "R6 later writeback");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule